// File: doc/BRIEF.md
# Subcycle Timing Recovery Slaved to a Sync Marker

This block sits inside a memory or peripheral device that shares a bus with a processor. The processor owns an eight-step, one-hot subcycle sequencer. It announces the boundary of each instruction cycle by driving a sync marker during the last subcycle. The recovery block keeps its own eight-stage one-hot ring and steps it on the same system-clock edges as the processor's sequencer. It snaps the ring back to the first subcycle whenever the marker has been seen. The local device then times its address capture, storage access and bus driving from the recovered subcycles.

Both chips run from one fast system clock. The two phase strobes are registered pulses derived from that clock, so each strobe stays high for one or more system-clock edges. The ring steps on the first system-clock edge at which the phase-one strobe is seen high after being low. This is the same rule the processor's sequencer uses, so the recovered outputs change on the same edge as the generated ones, with no skew.

After reset the outputs stay dark until the first marker has aligned the ring. A lock flag then stays high until the next reset. The block has no data stream: every pin is a plain control or status signal.

Top module: `subcycle_recover`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, all subcycle outputs and the lock flag are 0.
- R2: After reset, every subcycle output stays 0 and the lock flag stays 0 until the first marker-driven alignment, however many phase-one pulses arrive.
- R3: The marker is sampled on every system-clock edge at which the phase-two strobe is high. After at least one such sample is high, the next ring step loads the home pattern (bit 0 only, the first subcycle), whatever the ring held before.
- R4: At a ring step with no pending marker, an aligned ring rotates by one position: bit i moves to bit i+1, and bit NSUB-1 wraps to bit 0.
- R5: A ring step happens on exactly the system-clock edge at which the phase-one strobe is sampled high and was sampled low on the previous edge. The outputs do not change on any other edge.
- R6: A marker that is high only while the phase-two strobe is low has no effect on the outputs.
- R7: The lock flag rises on the same edge as the first alignment and stays high until reset.
- R8: At most one subcycle output is high at any time, and exactly one is high while locked.
- R9: Once aligned by the processor's own marker, the outputs equal the processor's sequencer outputs on every cycle. This also holds when the block leaves reset part-way through an instruction cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock shared with the processor |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk1 | input | 1 | Phase-one strobe, registered from clk; its rise steps the ring |
| clk2 | input | 1 | Phase-two strobe, registered from clk; the marker is sampled while it is high |
| sync_in | input | 1 | Instruction-cycle marker from the processor |
| subcyc | output | NSUB | One-hot recovered subcycles, bit 0 is the first subcycle |
| locked | output | 1 | High from the first marker-driven alignment until reset |

## Verification
The bench builds the block with its default of eight subcycles and home position 0. It pairs the block with a reference sequencer of the same width, so the wrap from the last subcycle to the first is reached on every instruction cycle. The strobe widths and gaps vary at random down to a single clock. This brings the one-edge-wide phase pulses within reach, where any skew between generator and recovery would show. Repeated resets of the block alone start it mid-cycle, and stray markers injected at random times test both realignment from an arbitrary position and rejection outside phase two.

// File: rtl/subcyc_pkg.sv
package subcyc_pkg;
  // number of subcycles in one instruction cycle
  localparam int unsigned SUBCYC_COUNT = 8;
  // ring position loaded by a marker-driven alignment
  localparam int unsigned SUBCYC_HOME  = 0;
endpackage

// File: rtl/subcyc_strobe_rise.sv
// Detects the first clk edge at which a registered strobe is high.
module subcyc_strobe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/subcyc_sync_latch.sv
// Holds a seen-marker flag from the sampling window until the next ring step.
module subcyc_sync_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic window,
  input  logic marker,
  input  logic consume,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~consume) | (window & marker);
  end
endmodule

// File: rtl/subcyc_ring.sv
// One-hot ring: dark after reset, loads home on aligned steps, else rotates.
module subcyc_ring #(
  parameter int unsigned NSUB = 8,
  parameter int unsigned HOME = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            load,
  output logic [NSUB-1:0] q
);
  localparam logic [NSUB-1:0] HOME_VEC = {{(NSUB-1){1'b0}}, 1'b1} << HOME;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (step) begin
      if (load) q <= HOME_VEC;
      else      q <= {q[NSUB-2:0], q[NSUB-1]};
    end
  end
endmodule

// File: rtl/subcycle_recover.sv
module subcycle_recover #(
  parameter int unsigned NSUB = subcyc_pkg::SUBCYC_COUNT,
  parameter int unsigned HOME = subcyc_pkg::SUBCYC_HOME
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk1,
  input  logic            clk2,
  input  logic            sync_in,
  output logic [NSUB-1:0] subcyc,
  output logic            locked
);
  logic adv;
  logic pend;

  subcyc_strobe_rise u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (clk1),
    .rise   (adv)
  );

  subcyc_sync_latch u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .window  (clk2),
    .marker  (sync_in),
    .consume (adv),
    .pend    (pend)
  );

  subcyc_ring #(.NSUB(NSUB), .HOME(HOME)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (adv),
    .load  (pend),
    .q     (subcyc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b0;
    else if (adv & pend) locked <= 1'b1;
  end
endmodule

// File: rtl/subcycle_recover_chk.sv
module subcycle_recover_chk #(
  parameter int unsigned NSUB = 8,
  parameter int unsigned HOME = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk2,
  input logic            sync_in,
  input logic            adv,
  input logic            pend,
  input logic [NSUB-1:0] subcyc,
  input logic            locked
);
  localparam logic [NSUB-1:0] HOME_VEC = {{(NSUB-1){1'b0}}, 1'b1} << HOME;
  logic [NSUB-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= subcyc;
  end

  // R8
  onehot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(subcyc) && (!locked || $countones(subcyc) == 1));
  // R2
  dark_until_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> subcyc == '0);
  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R3
  realign_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pend) |=> subcyc == HOME_VEC && locked);
  // R4
  ring_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pend && locked) |=> subcyc == {prev_q[NSUB-2:0], prev_q[NSUB-1]});
  // R5
  step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(subcyc));
  // R6
  stray_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk2 && !pend && !adv && sync_in) |=> !pend);
endmodule

bind subcycle_recover subcycle_recover_chk #(.NSUB(NSUB), .HOME(HOME)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk2    (clk2),
  .sync_in (sync_in),
  .adv     (adv),
  .pend    (pend),
  .subcyc  (subcyc),
  .locked  (locked)
);

// File: tb/sim_subcycle_recover.sv
// Reference sequencer: steps on the first clk edge of each phase-one pulse.
module ref_subcyc_gen #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph1,
  output logic [N-1:0] ring,
  output logic         mark
);
  logic ph1_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring  <= {{(N-1){1'b0}}, 1'b1};
      ph1_d <= 1'b0;
    end else begin
      ph1_d <= ph1;
      if (ph1 && !ph1_d) ring <= {ring[N-2:0], ring[N-1]};
    end
  end
  assign mark = ring[N-1];
endmodule

module sim_subcycle_recover;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic gen_rst_n, dut_rst_n;
  logic ph1, ph2, inj;
  logic gen_mark, sync_bus;
  logic [N-1:0] gen_ring, dut_sub;
  logic dut_locked;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int m_pos;
  bit m_pend, m_pend_gen, m_ph1q, m_clean;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sync_bus = gen_mark | inj;

  ref_subcyc_gen #(.N(N)) u_gen (
    .clk(clk), .rst_n(gen_rst_n), .ph1(ph1), .ring(gen_ring), .mark(gen_mark)
  );

  subcycle_recover #(.NSUB(N), .HOME(0)) u0 (
    .clk(clk), .rst_n(dut_rst_n), .clk1(ph1), .clk2(ph2),
    .sync_in(sync_bus), .subcyc(dut_sub), .locked(dut_locked)
  );

  function automatic logic [N-1:0] expect_sub(int pos);
    logic [N-1:0] v;
    v = '0;
    if (pos >= 0) v[pos] = 1'b1;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // registered phase strobes with random widths and gaps
  initial begin
    void'($urandom(32'h5eed_0141));
    ph1 = 1'b0; ph2 = 1'b0;
    forever begin
      @(posedge clk) ph1 <= 1'b1;
      repeat ($urandom_range(0, 2)) @(posedge clk);
      @(posedge clk) ph1 <= 1'b0;
      repeat ($urandom_range(0, 2)) @(posedge clk);
      @(posedge clk) ph2 <= 1'b1;
      repeat ($urandom_range(0, 2)) @(posedge clk);
      @(posedge clk) ph2 <= 1'b0;
      repeat ($urandom_range(0, 2)) @(posedge clk);
    end
  end

  // behavioural model of the requirements, updated from pre-edge values
  always @(posedge clk) begin
    if (!dut_rst_n) begin
      m_pos = -1; m_pend = 0; m_pend_gen = 0; m_ph1q = 0; m_clean = 0;
    end else begin
      if (ph1 && !m_ph1q) begin            // R5 step edge
        if (m_pend) begin                  // R3 load home
          m_pos = 0;
          m_clean = m_pend_gen;
        end else if (m_pos >= 0) begin     // R4 rotate
          m_pos = (m_pos + 1) % N;
        end
        m_pend = 0; m_pend_gen = 0;
      end
      if (ph2 && sync_bus) m_pend = 1;     // R6 only sampled in phase two
      if (ph2 && gen_mark) m_pend_gen = 1;
      m_ph1q = ph1;
    end
  end

  // output checks away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (done) break;
      if (!dut_rst_n) begin
        check(dut_sub == '0 && !dut_locked, "R1 reset state", dut_sub, '0);
      end else begin
        check(dut_sub == expect_sub(m_pos),
              (m_pos < 0) ? "R2 dark before lock" : "R3/R4/R5/R6 model",
              dut_sub, expect_sub(m_pos));
        check(dut_locked == (m_pos >= 0), "R7 lock flag",
              {{(N-1){1'b0}}, dut_locked}, {{(N-1){1'b0}}, (m_pos >= 0)});
        check($countones(dut_sub) <= 1 && (!dut_locked || $countones(dut_sub) == 1),
              "R8 one-hot", dut_sub, expect_sub(m_pos));
        if (m_pos >= 0 && m_clean && gen_rst_n)
          check(dut_sub == gen_ring, "R9 equal to generator", dut_sub, gen_ring);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    gen_rst_n = 1'b0; dut_rst_n = 1'b0; inj = 1'b0;
    repeat (5) @(posedge clk);
    gen_rst_n <= 1'b1; dut_rst_n <= 1'b1;
    repeat (500) @(posedge clk);           // R2 then R9 from a common reset

    for (int k = 0; k < 8; k++) begin      // R9 mid-cycle restarts, R1
      repeat ($urandom_range(1, 40)) @(posedge clk);
      dut_rst_n <= 1'b0;
      repeat ($urandom_range(1, 20)) @(posedge clk);
      dut_rst_n <= 1'b1;
      repeat (300) @(posedge clk);
    end

    for (int k = 0; k < 80; k++) begin     // R3 forced realign, R6 stray marker
      repeat ($urandom_range(5, 60)) @(posedge clk);
      inj <= 1'b1;
      repeat ($urandom_range(1, 4)) @(posedge clk);
      inj <= 1'b0;
    end
    repeat (400) @(posedge clk);           // R9 realigned by generator marker

    done = 1;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule